// File: doc/BRIEF.md
# Alarm Timer with Capture Registers

A 32-bit free-running timer that advances once per cycle of a slow real-time clock while its run bit is set. A 32-bit alarm comparator watches the count. On a match it raises a sticky flag, which drives the interrupt/wake output when the alarm is enabled. An optional auto-reset mode returns the count to zero one cycle after each match. This gives a periodic alarm with a period of the alarm value plus one.

Software never reads or writes the count directly. A 32-bit staging register sits between the bus and the counter. A self-clearing load command copies the staging register into the counter. A self-clearing snapshot command copies the counter into the staging register. Both commands work while the timer is running. The register bus has an address, write data and a write strobe, with combinational read data. The bus and the counter share one clock.

Top module: `alarm_timer`

## Requirements
- R1: After reset, the control word at address 0 reads 0, the staging register at address 1 reads 0, the alarm register at address 2 reads 0xFFFFFFFF, and the interrupt output is 0.
- R2: The count rises by one on each clock while the run bit (control bit 0) is 1, and holds while it is 0.
- R3: Without auto-reset, the count wraps from 0xFFFFFFFF to 0.
- R4: A match between the count and the alarm register while running sets the sticky alarm flag (control bit 5). Writing 1 to bit 5 of the control word clears the flag. A match in the same cycle wins over the clear.
- R5: The interrupt output is 1 exactly when the alarm flag is 1 and the alarm enable (control bit 2) is 1.
- R6: With auto-reset (control bit 1) set, the count becomes 0 on the clock after a match, so matches recur every alarm value plus one cycles.
- R7: Writing 1 to the load command (control bit 3) makes that bit read 1 for one cycle. On the next clock, the staging value enters the counter and the bit reads 0. The load takes priority over increment and auto-reset.
- R8: Writing 1 to the snapshot command (control bit 4) makes that bit read 1 for one cycle. On the next clock, the staging register takes the count held during that cycle and the bit reads 0. The snapshot takes priority over a bus write to the staging register.
- R9: Address 3 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Real-time oscillator clock, also used by the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr |
| alarm_irq | output | 1 | Alarm interrupt/wake request |

## Verification
Directed sequences load, snapshot and compare the count while stopped and while running. A stopped snapshot pair tells holding apart from counting, and a running pair tells increment from stall. A load near the top of the range checks the wrap. An auto-reset run with a small alarm value measures the match period, which tells a clear-on-match from a clear-after-match. A random mix of control, staging and alarm writes follows, with alarm values placed just ahead of the count. This mix makes load, snapshot, match and flag clear fall in the same cycles, so it exercises the priority rules.

// File: rtl/at_pkg.sv
// Package: register addresses and control-word bit positions shared by the
// alarm timer modules. Assumes a 2-bit word address.
package at_pkg;
    localparam int ADDR_W   = 2;
    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAGE = 2'd1;
    localparam logic [ADDR_W-1:0] A_ALARM = 2'd2;
    localparam int B_RUN   = 0;
    localparam int B_AUTO  = 1;
    localparam int B_EN    = 2;
    localparam int B_LOAD  = 3;
    localparam int B_SNAP  = 4;
    localparam int B_FLAG  = 5;
    localparam int CTRL_BITS = 6;
endpackage

// File: rtl/at_counter.sv
// Module: at_counter
// The timer itself. Priority per clock: load from staging, auto-reset clear
// after a match, increment while running, hold. Assumes load_pend lasts
// exactly one cycle. The match output is a compare on registered state.
module at_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         auto_rst,
    input  logic         load_pend,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] alarm_val,
    output logic [W-1:0] count,
    output logic         match
);
    // Compare the current count with the alarm register
    always_comb match = (count == alarm_val);

    // Advance, clear or load the count
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load_pend)
            count <= load_val;
        else if (run && match && auto_rst)
            count <= '0;
        else if (run)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/at_regs.sv
// Module: at_regs
// Bus-facing register file: control word, staging register and alarm
// register, the one-cycle load/snapshot command bits and the sticky flag.
// Assumes one write per cycle and a combinational read path.
module at_regs
    import at_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    input  logic              bus_we,
    input  logic [W-1:0]      count,
    input  logic              match,
    output logic              run,
    output logic              auto_rst,
    output logic              alarm_en,
    output logic              load_pend,
    output logic              snap_pend,
    output logic              flag,
    output logic [W-1:0]      stage,
    output logic [W-1:0]      alarm_val,
    output logic [W-1:0]      bus_rdata
);
    localparam int PAD = W - CTRL_BITS;

    logic wr_ctrl, wr_stage, wr_alarm;

    // Decode the write strobe per register
    always_comb begin
        wr_ctrl  = bus_we && (bus_addr == A_CTRL);
        wr_stage = bus_we && (bus_addr == A_STAGE);
        wr_alarm = bus_we && (bus_addr == A_ALARM);
    end

    // Mode bits and the self-clearing command bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run       <= 1'b0;
            auto_rst  <= 1'b0;
            alarm_en  <= 1'b0;
            load_pend <= 1'b0;
            snap_pend <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                run      <= bus_wdata[B_RUN];
                auto_rst <= bus_wdata[B_AUTO];
                alarm_en <= bus_wdata[B_EN];
            end
            load_pend <= wr_ctrl && bus_wdata[B_LOAD];
            snap_pend <= wr_ctrl && bus_wdata[B_SNAP];
        end
    end

    // Sticky alarm flag: a match sets it, write-one clears it
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (run && match)
            flag <= 1'b1;
        else if (wr_ctrl && bus_wdata[B_FLAG])
            flag <= 1'b0;
    end

    // Staging register: a snapshot wins over a bus write
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage <= '0;
        else if (snap_pend)
            stage <= count;
        else if (wr_stage)
            stage <= bus_wdata;
    end

    // Alarm compare value
    always_ff @(posedge clk) begin
        if (!rst_n)
            alarm_val <= '1;
        else if (wr_alarm)
            alarm_val <= bus_wdata;
    end

    // Read multiplexer, address 3 reads zero
    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = {{PAD{1'b0}}, flag, snap_pend, load_pend,
                                  alarm_en, auto_rst, run};
            A_STAGE: bus_rdata = stage;
            A_ALARM: bus_rdata = alarm_val;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/alarm_timer.sv
// Module: alarm_timer (top)
// Alarm timer with a staging register for load and snapshot. Assumes the bus
// and the counter share clk. The interrupt is the flag gated by the enable.
module alarm_timer
    import at_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    input  logic              bus_we,
    output logic [W-1:0]      bus_rdata,
    output logic              alarm_irq
);
    logic         run, auto_rst, alarm_en, load_pend, snap_pend, flag, match;
    logic [W-1:0] stage, alarm_val, count;

    at_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .count(count), .match(match), .run(run),
        .auto_rst(auto_rst), .alarm_en(alarm_en), .load_pend(load_pend),
        .snap_pend(snap_pend), .flag(flag), .stage(stage),
        .alarm_val(alarm_val), .bus_rdata(bus_rdata)
    );

    at_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .auto_rst(auto_rst),
        .load_pend(load_pend), .load_val(stage), .alarm_val(alarm_val),
        .count(count), .match(match)
    );

    // Gate the sticky flag onto the interrupt/wake output
    always_comb alarm_irq = flag && alarm_en;
endmodule

// File: rtl/alarm_timer_chk.sv
// Module: alarm_timer_chk
// Checker bound into alarm_timer. Relates the counter, the register file and
// the bus over time.
module alarm_timer_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_we,
    input logic [1:0]   bus_addr,
    input logic         run,
    input logic         auto_rst,
    input logic         load_pend,
    input logic         snap_pend,
    input logic         flag,
    input logic         match,
    input logic [W-1:0] count,
    input logic [W-1:0] stage
);
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_pend) |=> $stable(count));
    // R2
    incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load_pend && !(match && auto_rst)) |=> count == $past(count) + 1'b1);
    // R6
    auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && match && auto_rst && !load_pend) |=> count == '0);
    // R7
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_pend |=> count == $past(stage));
    // R7
    load_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pend && !(bus_we && bus_addr == 2'd0)) |=> !load_pend);
    // R8
    snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_pend |=> stage == $past(count));
    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && match) |=> flag);
endmodule

bind alarm_timer alarm_timer_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .run(run), .auto_rst(auto_rst), .load_pend(load_pend),
    .snap_pend(snap_pend), .flag(flag), .match(match), .count(count),
    .stage(stage)
);

// File: tb/alarm_timer_bench.sv
// Bench: directed corner cases, then a seeded random mix. A cycle model built
// from the requirements predicts bus_rdata and alarm_irq on every cycle.
module alarm_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        alarm_irq;
    int checks = 0, errors = 0;
    bit done = 0;

    alarm_timer u_alarm_timer (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
        .alarm_irq(alarm_irq));

    always #2 clk = ~clk;

    // Requirement model state
    logic [31:0] m_cnt, m_stage, m_alarm;
    logic m_run, m_auto, m_en, m_load, m_snap, m_flag;

    always @(posedge clk) begin
        logic wc, mt;
        wc = bus_we && bus_addr == 2'd0;
        mt = (m_cnt == m_alarm);
        if (!rst_n) begin
            m_cnt <= 0; m_stage <= 0; m_alarm <= 32'hFFFF_FFFF;
            m_run <= 0; m_auto <= 0; m_en <= 0; m_load <= 0; m_snap <= 0; m_flag <= 0;
        end else begin
            if (m_load) m_cnt <= m_stage;
            else if (m_run && mt && m_auto) m_cnt <= 0;
            else if (m_run) m_cnt <= m_cnt + 1;
            if (m_snap) m_stage <= m_cnt;
            else if (bus_we && bus_addr == 2'd1) m_stage <= bus_wdata;
            if (bus_we && bus_addr == 2'd2) m_alarm <= bus_wdata;
            if (wc) begin m_run <= bus_wdata[0]; m_auto <= bus_wdata[1]; m_en <= bus_wdata[2]; end
            m_load <= wc && bus_wdata[3];
            m_snap <= wc && bus_wdata[4];
            if (m_run && mt) m_flag <= 1;
            else if (wc && bus_wdata[5]) m_flag <= 0;
        end
    end

    function automatic logic [31:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return {26'd0, m_flag, m_snap, m_load, m_en, m_auto, m_run};
            2'd1: return m_stage;
            2'd2: return m_alarm;
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle, then a model comparison away from the edge
    task automatic cyc(input logic we, input logic [1:0] a, input logic [31:0] d);
        bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_we = 0;
        check("R2/R4/R6/R7/R8/R9 model read", bus_rdata, exp_read(a));
        check("R5 model irq", {31'd0, alarm_irq}, {31'd0, m_flag && m_en});
    endtask

    logic [31:0] v1, v2;

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        cyc(0, 2'd0, 0); check("R1 ctrl", bus_rdata, 0);
        check("R1 irq", {31'd0, alarm_irq}, 0);
        cyc(0, 2'd1, 0); check("R1 staging", bus_rdata, 0);
        cyc(0, 2'd2, 0); check("R1 alarm", bus_rdata, 32'hFFFF_FFFF);
        // R7 load command visible for one cycle
        cyc(1, 2'd1, 32'd100);
        cyc(1, 2'd0, 32'h8); check("R7 load bit set", {31'd0, bus_rdata[3]}, 1);
        cyc(0, 2'd0, 0);     check("R7 load bit cleared", {31'd0, bus_rdata[3]}, 0);
        // R8 snapshot of a stopped count
        cyc(1, 2'd0, 32'h10); check("R8 snap bit set", {31'd0, bus_rdata[4]}, 1);
        cyc(0, 2'd1, 0);      check("R8 snapshot value", bus_rdata, 32'd100);
        // R2 stopped: two snapshots agree
        cyc(1, 2'd0, 32'h10); cyc(0, 2'd1, 0); v1 = bus_rdata;
        check("R2 hold", v1, 32'd100);
        // R2 running: snapshots two cycles apart differ by two
        cyc(1, 2'd0, 32'h1);
        cyc(1, 2'd0, 32'h11); cyc(0, 2'd1, 0); v1 = bus_rdata;
        cyc(1, 2'd0, 32'h11); cyc(0, 2'd1, 0); v2 = bus_rdata;
        check("R2 increment", v2 - v1, 32'd2);
        // R3 wrap through the top of the range
        cyc(1, 2'd0, 32'h0); cyc(1, 2'd1, 32'hFFFF_FFFE);
        cyc(1, 2'd0, 32'h8); cyc(0, 2'd0, 0);
        cyc(1, 2'd0, 32'h1); cyc(1, 2'd0, 32'h11); cyc(0, 2'd1, 0);
        check("R3 before wrap", bus_rdata, 32'hFFFF_FFFF);
        cyc(1, 2'd0, 32'h11); cyc(0, 2'd1, 0);
        check("R3 after wrap", bus_rdata, 32'd1);
        // R5 flag set by the all-ones match but not enabled
        cyc(0, 2'd0, 0);
        check("R4 flag sticky", {31'd0, bus_rdata[5]}, 1);
        check("R5 irq gated off", {31'd0, alarm_irq}, 0);
        cyc(1, 2'd0, 32'h5); check("R5 irq enabled", {31'd0, alarm_irq}, 1);
        cyc(1, 2'd0, 32'h25); check("R4 write-one clear", {31'd0, bus_rdata[5]}, 0);
        // R6 auto-reset period is alarm value plus one
        cyc(1, 2'd0, 32'h0); cyc(1, 2'd1, 0); cyc(1, 2'd0, 32'h8);
        cyc(1, 2'd2, 32'd9); cyc(1, 2'd0, 32'h7);
        begin
            int n = 0;
            while (!alarm_irq && n < 50) begin cyc(0, 2'd0, 0); n++; end
            n = 1;
            cyc(1, 2'd0, 32'h27);
            while (!alarm_irq && n < 50) begin cyc(0, 2'd0, 0); n++; end
            check("R6 period", n, 32'd10);
        end
        // R9 reserved address
        cyc(1, 2'd3, 32'hFFFF_FFFF); check("R9 reserved read", bus_rdata, 0);
        cyc(0, 2'd2, 0); check("R9 alarm untouched", bus_rdata, 32'd9);
        // Random mix, model-checked each cycle
        for (int i = 0; i < 4000; i++) begin
            int op = $urandom_range(0, 9);
            logic [1:0] ra = 2'($urandom_range(0, 3));
            if (op < 3)
                cyc(0, ra, 0);
            else if (op < 6)
                cyc(1, 2'd0, {26'd0, 6'($urandom)} | ($urandom_range(0, 3) != 0 ? 32'h1 : 32'h0));
            else if (op < 8)
                cyc(1, 2'd1, ($urandom_range(0, 1) != 0) ? $urandom : m_cnt + 32'($urandom_range(0, 6)));
            else
                cyc(1, 2'd2, m_cnt + 32'($urandom_range(0, 8)));
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule